// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address. The segment is shifted left by four bits and the offset is added; the sum wraps within a 1 MiB space. Four segment registers (code, data, stack, extra) and an instruction pointer are held inside the block.

Each request is either an instruction fetch or a data access. A fetch always pairs the code segment with the instruction pointer. A data access names the register that supplied the offset. That source selects the default segment: the data segment for the base register and the two index registers, and the stack segment for the stack and frame pointers. An optional override replaces the default segment for data accesses. Any other source, including the byte halves of a register, is refused, and an error flag is raised. The instruction pointer advances by a fetch length every cycle and loads a new value on a jump strobe. The result is registered, one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: A request (`req_i`=1) sampled at a clock edge produces its result at that edge: either `addr_vld_o`=1 or `base_err_o`=1, never both. A cycle without a request drives both flags to 0 at the next edge. After reset both flags are 0 and `addr_o` is 0.
- R2: The address is the segment shifted left by 4 plus the zero-extended offset. For example, 1230h:0045h gives 12345h.
- R3: The 20-bit sum wraps modulo 2^20. FFFFh:0010h gives 00000h and FFFFh:FFFFh gives 0FFEFh.
- R4: A segment write (`seg_we_i`=1) stores `seg_wdata_i` at the clock edge into the register selected by `seg_wsel_i`: 0 extra, 1 code, 2 stack, 3 data. Reset clears all four.
- R5: A data access whose `base_i` is 3 (base register), 6 (source index) or 7 (destination index) uses the data segment by default.
- R6: A data access whose `base_i` is 4 (stack pointer) or 5 (frame pointer) uses the stack segment by default.
- R7: A data access whose `base_i` is 0, 1 or 2 (the three remaining word registers) or 8 to 15 (byte halves, with 11 and 15 the low and high halves of the base register) sets `base_err_o`=1 and `addr_vld_o`=0. An override does not clear the error.
- R8: For a data access with `ovr_en_i`=1, the segment coded by `ovr_sel_i` (same codes as R4) replaces the default segment.
- R9: A fetch (`fetch_i`=1) uses the code segment and the current instruction pointer. It ignores `base_i`, `off_i` and the override.
- R10: The instruction pointer resets to 0 and adds `ip_len_i` at every clock edge, wrapping modulo 2^16.
- R11: `jump_i`=1 loads `jump_ip_i` into the instruction pointer, taking priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write strobe |
| seg_wsel_i | input | 2 | Segment register to write |
| seg_wdata_i | input | 16 | Segment write value |
| req_i | input | 1 | Address request |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| base_i | input | 4 | Register that supplied the offset |
| off_i | input | 16 | Data offset |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_sel_i | input | 2 | Override segment |
| ip_len_i | input | 3 | Instruction pointer advance per cycle |
| jump_i | input | 1 | Instruction pointer load strobe |
| jump_ip_i | input | 16 | Instruction pointer load value |
| addr_o | output | 20 | Registered physical address |
| addr_vld_o | output | 1 | Address valid |
| base_err_o | output | 1 | Refused offset source |

## Verification
Each segment register is loaded with a distinct value, so every source code shows its segment choice in the upper address bits. The overrides are set to segments other than the defaults, which shows whether the override or the default was used. Offsets at the edge of the range and an all-ones segment show whether the carry past bit 19 is dropped. Fetches are issued with a refused source code, a live override and a non-zero data offset, which shows that a fetch depends only on the code segment and the instruction pointer. Jump, increment and wrap sequences set the pointer value that the fetch address then reflects.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [3:0] {
    SRC_AX = 4'd0, SRC_CX = 4'd1, SRC_DX = 4'd2, SRC_BX = 4'd3,
    SRC_SP = 4'd4, SRC_BP = 4'd5, SRC_SI = 4'd6, SRC_DI = 4'd7,
    SRC_AL = 4'd8, SRC_CL = 4'd9, SRC_DL = 4'd10, SRC_BL = 4'd11,
    SRC_AH = 4'd12, SRC_CH = 4'd13, SRC_DH = 4'd14, SRC_BH = 4'd15
  } off_src_e;

  localparam int unsigned NUM_SEG = 4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       wsel_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic [1:0]       rsel_i,
  output logic [SEG_W-1:0] rdata_o
);
  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   seg_q[g] <= '0;
      else if (we_i && (wsel_i == 2'(g)))            seg_q[g] <= wdata_i;
    end

    // R4: a write lands in exactly the selected register
    p_seg_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wsel_i == 2'(g)) |=> (seg_q[g] == $past(wdata_i)));
  end

  assign rdata_o = seg_q[rsel_i];
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic       fetch_i,
  input  logic [3:0] base_i,
  input  logic       ovr_en_i,
  input  logic [1:0] ovr_sel_i,
  output logic [1:0] sel_o,
  output logic       bad_base_o
);
  seg_id_e dflt;

  always_comb begin
    dflt       = SEG_DATA;
    bad_base_o = 1'b0;
    unique case (off_src_e'(base_i))
      SRC_BX, SRC_SI, SRC_DI: dflt = SEG_DATA;
      SRC_SP, SRC_BP:         dflt = SEG_STACK;
      default:                bad_base_o = !fetch_i;
    endcase
    if (fetch_i)       sel_o = SEG_CODE;
    else if (ovr_en_i) sel_o = ovr_sel_i;
    else               sel_o = dflt;
  end
endmodule

// File: rtl/ip_counter.sv
module ip_counter #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] len_i,
  input  logic             jump_i,
  input  logic [OFF_W-1:0] jump_ip_i,
  output logic [OFF_W-1:0] ip_o
);
  logic [OFF_W-1:0] ip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ip_q <= '0;
    else if (jump_i) ip_q <= jump_ip_i;
    else             ip_q <= ip_q + OFF_W'(len_i);
  end

  assign ip_o = ip_q;

  p_jump_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> (ip_o == $past(jump_ip_i)));

  p_ip_advance_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_i |=> (ip_o == OFF_W'($past(ip_o) + OFF_W'($past(len_i)))));
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  // sum kept at ADDR_W bits: carry out of the top bit is dropped
  assign addr_o = {seg_i, {SHIFT{1'b0}}} + ADDR_W'(off_i);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned LEN_W  = 3,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_we_i,
  input  logic [1:0]        seg_wsel_i,
  input  logic [SEG_W-1:0]  seg_wdata_i,
  input  logic              req_i,
  input  logic              fetch_i,
  input  logic [3:0]        base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              ovr_en_i,
  input  logic [1:0]        ovr_sel_i,
  input  logic [LEN_W-1:0]  ip_len_i,
  input  logic              jump_i,
  input  logic [OFF_W-1:0]  jump_ip_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic              base_err_o
);
  logic [1:0]        seg_sel;
  logic              bad_base;
  logic [SEG_W-1:0]  seg_val;
  logic [OFF_W-1:0]  ip;
  logic [OFF_W-1:0]  off_mux;
  logic [ADDR_W-1:0] addr_d;

  seg_regfile #(.SEG_W(SEG_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .wsel_i(seg_wsel_i), .wdata_i(seg_wdata_i),
    .rsel_i(seg_sel), .rdata_o(seg_val)
  );

  seg_select i_sel (
    .fetch_i, .base_i, .ovr_en_i, .ovr_sel_i,
    .sel_o(seg_sel), .bad_base_o(bad_base)
  );

  ip_counter #(.OFF_W(OFF_W), .LEN_W(LEN_W)) i_ip (
    .clk_i, .rst_ni, .len_i(ip_len_i), .jump_i, .jump_ip_i, .ip_o(ip)
  );

  assign off_mux = fetch_i ? ip : off_i;

  addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) i_add (
    .seg_i(seg_val), .off_i(off_mux), .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
      base_err_o <= 1'b0;
    end else begin
      addr_vld_o <= req_i && !bad_base;
      base_err_o <= req_i && bad_base;
      if (req_i) addr_o <= bad_base ? '0 : addr_d;
    end
  end

  p_req_answered_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (addr_vld_o != base_err_o));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!addr_vld_o && !base_err_o));

  p_bad_base_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !fetch_i && (base_i < 4'd3)) |=> (base_err_o && !addr_vld_o));

  p_byte_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !fetch_i && base_i[3]) |=> base_err_o);

  p_fetch_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && fetch_i) |=> addr_vld_o);
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req = 1'b0, fetch = 1'b0;
  logic [3:0]  base = '0;
  logic [15:0] off = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [2:0]  ip_len = '0;
  logic        jump = 1'b0;
  logic [15:0] jump_ip = '0;
  logic [19:0] addr;
  logic        vld, err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_we_i(seg_we), .seg_wsel_i(seg_wsel), .seg_wdata_i(seg_wdata),
    .req_i(req), .fetch_i(fetch), .base_i(base), .off_i(off),
    .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel), .ip_len_i(ip_len),
    .jump_i(jump), .jump_ip_i(jump_ip),
    .addr_o(addr), .addr_vld_o(vld), .base_err_o(err)
  );

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %05h expected %05h", tag, got, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
    @(negedge clk); seg_we = 1'b0;
  endtask

  // drive a request for one edge, return registered outputs
  task automatic do_req(input logic f, input logic [3:0] b, input logic [15:0] o,
                        input logic oe, input logic [1:0] os);
    @(negedge clk);
    req = 1'b1; fetch = f; base = b; off = o; ovr_en = oe; ovr_sel = os;
    @(negedge clk);
    req = 1'b0; ovr_en = 1'b0;
  endtask

  task automatic exp_data(input string tag, input logic [3:0] b, input logic [15:0] o,
                          input logic oe, input logic [1:0] os, input logic [19:0] exp);
    do_req(1'b0, b, o, oe, os);
    check({tag, " addr"}, addr, exp);
    check({tag, " vld/err"}, {18'd0, vld, err}, 20'd2);
  endtask

  task automatic exp_err(input string tag, input logic [3:0] b, input logic oe);
    do_req(1'b0, b, 16'h0045, oe, 2'd3);
    check({tag, " vld/err"}, {18'd0, vld, err}, 20'd1);
  endtask

  task automatic t_reset;
    check("R1 reset addr", addr, 20'h0);
    check("R1 reset flags", {18'd0, vld, err}, 20'd0);
    do_req(1'b1, 4'd0, 16'h0, 1'b0, 2'd0);
    check("R10 reset ip fetch", addr, 20'h0);
  endtask

  task automatic t_default_seg;
    exp_data("R2 BX 1230:0045", 4'd3, 16'h0045, 1'b0, 2'd0, 20'h12345);
    exp_data("R5 SI", 4'd6, 16'h0010, 1'b0, 2'd0, 20'h12310);
    exp_data("R5 DI", 4'd7, 16'hFFFF, 1'b0, 2'd0, 20'h222FF);
    exp_data("R6 SP", 4'd4, 16'h0002, 1'b0, 2'd0, 20'h40002);
    exp_data("R6 BP", 4'd5, 16'h1234, 1'b0, 2'd0, 20'h41234);
    @(negedge clk);
    check("R1 idle flags", {18'd0, vld, err}, 20'd0);
  endtask

  task automatic t_override;
    exp_data("R8 BX over extra", 4'd3, 16'h0001, 1'b1, 2'd0, 20'h50001);
    exp_data("R8 SP over code", 4'd4, 16'h0000, 1'b1, 2'd1, 20'h20000);
    exp_data("R8 SI over stack", 4'd6, 16'h0007, 1'b1, 2'd2, 20'h40007);
  endtask

  task automatic t_bad_base;
    exp_err("R7 AX", 4'd0, 1'b0);
    exp_err("R7 DX", 4'd2, 1'b0);
    exp_err("R7 BL", 4'd11, 1'b0);
    exp_err("R7 BH", 4'd15, 1'b0);
    exp_err("R7 CX with override", 4'd1, 1'b1);
  endtask

  task automatic t_wrap;
    wr_seg(2'd3, 16'hFFFF);
    exp_data("R3 FFFF:0010", 4'd3, 16'h0010, 1'b0, 2'd0, 20'h00000);
    exp_data("R3 FFFF:FFFF", 4'd7, 16'hFFFF, 1'b0, 2'd0, 20'h0FFEF);
    wr_seg(2'd3, 16'h1230);
  endtask

  task automatic t_ip;
    @(negedge clk); jump = 1'b1; jump_ip = 16'h0100; ip_len = 3'd5;
    @(negedge clk); jump = 1'b0; ip_len = 3'd2;
    @(negedge clk);
    @(negedge clk); ip_len = 3'd0;
    // fetch ignores bad base, override and data offset
    do_req(1'b1, 4'd0, 16'h1234, 1'b1, 2'd0);
    check("R9 R10 R11 fetch CS:IP", addr, 20'h20104);
    check("R9 fetch flags", {18'd0, vld, err}, 20'd2);
    @(negedge clk); jump = 1'b1; jump_ip = 16'hFFFF;
    @(negedge clk); jump = 1'b0; ip_len = 3'd3;
    @(negedge clk); ip_len = 3'd0;
    do_req(1'b1, 4'd3, 16'h0, 1'b0, 2'd0);
    check("R10 ip wrap", addr, 20'h20002);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr_seg(2'd1, 16'h2000);
    wr_seg(2'd3, 16'h1230);
    wr_seg(2'd2, 16'h4000);
    wr_seg(2'd0, 16'h5000);
    // R4: code segment write visible through a fetch (ip = 0)
    do_req(1'b1, 4'd0, 16'h0, 1'b0, 2'd0);
    check("R4 code write", addr, 20'h20000);
    t_default_seg();
    t_override();
    t_bad_base();
    t_wrap();
    t_ip();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule